// File: doc/BRIEF.md
# Dual-Channel CAN Clock Prescaler Control

This block holds one 8-bit control register that sets up the clocks of two CAN controller channels. Each channel has a 3-bit divide code and a sleep flag for its CPU interface. The divide code selects how far the incoming clock is divided before it is handed to the channel. The sleep flag parks the channel's CPU interface and holds its divided clock low.

Software writes the register through a simple write strobe with address and data. A write only takes hold when a separate protect register has opened this register for writing. Each field also has its own guard. A divide code can change only while its channel's controller is in reset/initialization mode. A sleep flag can be raised only after the controller has enabled its sleep mode. Reserved divide codes are refused. When only some fields of a write are refused, the allowed fields of that same write are still applied.

Each channel's clock generator picks up a new ratio or sleep state only at the end of its current output period. Because of this, a change never shortens a pulse.

Top module: `canClkPrescaler`

## Requirements
- R1: After reset the register reads 00h, both sleep outputs are 0, and both divided clocks follow the input clock undivided.
- R2: The register value is visible on rdData at all times. Channel 0 holds its divide code in bits 2:0 and its sleep flag in bit 3. Channel 1 holds its divide code in bits 6:4 and its sleep flag in bit 7. A write that is accepted is visible on the cycle after its clock edge.
- R3: A write is considered only when wrEn is 1, wrAddr equals REG_ADDR and protEn is 1. Any other write leaves the whole register unchanged.
- R4: A channel's divide code is updated only when that channel's chResetMode bit is 1 during the write.
- R5: Divide codes 5, 6 and 7 are reserved. Writing one of them leaves that channel's code unchanged.
- R6: Writing 1 to a sleep flag takes effect only when that channel's chSleepEnabled bit is 1. Writing 0 to a sleep flag takes effect whenever the write is accepted under R3.
- R7: A field that is refused under R4, R5 or R6 keeps its old value. The other fields of the same write are still applied.
- R8: Divide code k gives an output period of 2^k input clocks. For k of 1 or more, the output is high for the first half of the period and low for the second half. Code 0 passes the input clock straight through.
- R9: After a ratio change, the divided clock finishes its current period at the old ratio before switching, so no high or low phase is cut short.
- R10: While a channel's sleep flag is 1, its divided clock is held low from the next period boundary onward. Clearing the flag resumes clocking at the programmed ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock for both channels |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Write data |
| protEn | input | 1 | Write-enable bit from the protect register |
| chResetMode | input | 2 | Per channel: the controller is in reset/initialization mode |
| chSleepEnabled | input | 2 | Per channel: the controller has its sleep mode enabled |
| rdData | output | 8 | Current register value |
| divClk | output | 2 | Divided clock for each channel |
| chSleep | output | 2 | Sleep flag for each channel's CPU interface |

## Verification
The assertions assume that the status inputs and the write strobe change only between clock edges and are stable at the sampling edge. They also assume that reset is held for at least one edge. The bench drives every input on the falling edge of the clock to stay within these assumptions. The random writes mix matching and non-matching addresses, open and closed protection, reserved codes and every combination of the status flags. Ratio and sleep checks are made only after a settling window of more than one longest period.

// File: rtl/canpre_pkg.sv
package canpre_pkg;
  localparam int NUM_CH   = 2;
  localparam int CODE_W   = 3;
  localparam int FIELD_W  = CODE_W + 1;
  localparam int REG_W    = NUM_CH * FIELD_W;
  localparam int MAX_CODE = 4;

  typedef struct packed {
    logic [NUM_CH-1:0] divWe;
    logic [NUM_CH-1:0] sleepWe;
  } wrStrobe_t;
endpackage

// File: rtl/canpre_ctrl.sv
module canpre_ctrl
  import canpre_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] REG_ADDR = 10'h040
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              protEn,
  input  logic [NUM_CH-1:0] chResetMode,
  input  logic [NUM_CH-1:0] chSleepEnabled,
  output wrStrobe_t         strobe
);
  logic accept;
  assign accept = wrEn && (wrAddr == REG_ADDR) && protEn;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CODE_W-1:0] reqCode;
    logic              reqSleep;
    assign reqCode  = wrData[ch*FIELD_W +: CODE_W];
    assign reqSleep = wrData[ch*FIELD_W + CODE_W];
    assign strobe.divWe[ch]   = accept && chResetMode[ch] &&
                                (reqCode <= CODE_W'(MAX_CODE));
    assign strobe.sleepWe[ch] = accept && (!reqSleep || chSleepEnabled[ch]);
  end
endmodule

// File: rtl/canpre_divider.sv
module canpre_divider #(
  parameter int CODE_W   = 3,
  parameter int MAX_CODE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] newCode,
  input  logic              newSleep,
  output logic              divClk
);
  localparam int CNT_W = (MAX_CODE > 0) ? MAX_CODE : 1;

  logic [CODE_W-1:0] actCode;
  logic              actSleep;
  logic [CNT_W-1:0]  cnt;
  logic              divQ;

  logic [CNT_W:0]    lastCnt;
  logic              boundary;
  logic [CODE_W-1:0] nextCode;
  logic [CNT_W-1:0]  nextCnt;
  logic [CNT_W:0]    halfLen;

  always_comb begin
    lastCnt  = ((CNT_W+1)'(1) << actCode) - (CNT_W+1)'(1);
    boundary = (actCode == '0) || ({1'b0, cnt} == lastCnt);
    nextCode = boundary ? newCode : actCode;
    nextCnt  = boundary ? '0 : cnt + CNT_W'(1);
    halfLen  = ((CNT_W+1)'(1) << nextCode) >> 1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actCode  <= '0;
      actSleep <= 1'b0;
      cnt      <= '0;
      divQ     <= 1'b0;
    end else begin
      actCode <= nextCode;
      cnt     <= nextCnt;
      divQ    <= (nextCode != '0) && ({1'b0, nextCnt} < halfLen);
      if (boundary) actSleep <= newSleep;
    end
  end

  assign divClk = !actSleep && ((actCode == '0) ? clk : divQ);
endmodule

// File: rtl/canpre_datapath.sv
module canpre_datapath
  import canpre_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  output logic [NUM_CH-1:0] divClk,
  output logic [NUM_CH-1:0] chSleep
);
  logic [REG_W-1:0] regQ;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int LSB = ch * FIELD_W;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        regQ[LSB +: FIELD_W] <= '0;
      end else begin
        if (strobe.divWe[ch])   regQ[LSB +: CODE_W]   <= wrData[LSB +: CODE_W];
        if (strobe.sleepWe[ch]) regQ[LSB + CODE_W]    <= wrData[LSB + CODE_W];
      end
    end

    assign chSleep[ch] = regQ[LSB + CODE_W];

    canpre_divider #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_div (
      .clk     (clk),
      .rstN    (rstN),
      .newCode (regQ[LSB +: CODE_W]),
      .newSleep(regQ[LSB + CODE_W]),
      .divClk  (divClk[ch])
    );
  end

  assign rdData = regQ;
endmodule

// File: rtl/canClkPrescaler.sv
module canClkPrescaler
  import canpre_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] REG_ADDR = 10'h040
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              protEn,
  input  logic [1:0]        chResetMode,
  input  logic [1:0]        chSleepEnabled,
  output logic [7:0]        rdData,
  output logic [1:0]        divClk,
  output logic [1:0]        chSleep
);
  wrStrobe_t strobe;

  canpre_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctrl (
    .wrEn          (wrEn),
    .wrAddr        (wrAddr),
    .wrData        (wrData),
    .protEn        (protEn),
    .chResetMode   (chResetMode),
    .chSleepEnabled(chSleepEnabled),
    .strobe        (strobe)
  );

  canpre_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .rdData (rdData),
    .divClk (divClk),
    .chSleep(chSleep)
  );
endmodule

// File: rtl/canpre_checker.sv
module canpre_checker #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] REG_ADDR = 10'h040
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [7:0]        wrData,
  input logic              protEn,
  input logic [1:0]        chResetMode,
  input logic [1:0]        chSleepEnabled,
  input logic [7:0]        rdData,
  input logic [1:0]        divClk,
  input logic [1:0]        chSleep
);
  logic hit;
  assign hit = wrEn && (wrAddr == REG_ADDR) && protEn;

  logic [4:0] sleepRun0, sleepRun1;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sleepRun0 <= '0;
      sleepRun1 <= '0;
    end else begin
      sleepRun0 <= !chSleep[0] ? 5'd0 : (sleepRun0 == 5'd20 ? sleepRun0 : sleepRun0 + 5'd1);
      sleepRun1 <= !chSleep[1] ? 5'd0 : (sleepRun1 == 5'd20 ? sleepRun1 : sleepRun1 + 5'd1);
    end
  end

  assert_blocked_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    !hit |=> $stable(rdData));

  assert_code_lock0_R4: assert property (@(posedge clk) disable iff (!rstN)
    !chResetMode[0] |=> rdData[2:0] == $past(rdData[2:0]));

  assert_code_lock1_R4: assert property (@(posedge clk) disable iff (!rstN)
    !chResetMode[1] |=> rdData[6:4] == $past(rdData[6:4]));

  assert_no_reserved_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[2:0] <= 3'd4) && (rdData[6:4] <= 3'd4));

  assert_sleep_gate0_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!chSleepEnabled[0] && !chSleep[0]) |=> !chSleep[0]);

  assert_sleep_gate1_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!chSleepEnabled[1] && !chSleep[1]) |=> !chSleep[1]);

  assert_sleep_low0_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sleepRun0 >= 5'd17) |-> !divClk[0]);

  assert_sleep_low1_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sleepRun1 >= 5'd17) |-> !divClk[1]);
endmodule

bind canClkPrescaler canpre_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (.*);

// File: tb/tb_canClkPrescaler.sv
module tb_canClkPrescaler;
  localparam int ADDR_W = 10;
  localparam logic [ADDR_W-1:0] REG_ADDR = 10'h040;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic protEn = 1'b0;
  logic [1:0] chResetMode = '0;
  logic [1:0] chSleepEnabled = '0;
  logic [7:0] rdData;
  logic [1:0] divClk;
  logic [1:0] chSleep;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] model = '0;

  always #5 clk = ~clk;

  canClkPrescaler #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] refWrite(input logic [7:0] old, input logic [7:0] d,
      input logic [ADDR_W-1:0] a, input logic p, input logic [1:0] rm, input logic [1:0] se);
    logic [7:0] r = old;
    if (a == REG_ADDR && p) begin
      for (int ch = 0; ch < 2; ch++) begin
        if (rm[ch] && d[ch*4 +: 3] <= 3'd4) r[ch*4 +: 3] = d[ch*4 +: 3];
        if (!d[ch*4+3] || se[ch]) r[ch*4+3] = d[ch*4+3];
      end
    end
    return r;
  endfunction

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    model = refWrite(model, d, a, protEn, chResetMode, chSleepEnabled);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic sampleBit(input int ch, output logic v);
    @(posedge clk);
    #2;
    v = divClk[ch];
  endtask

  task automatic measure(input int ch, input int n, input string req);
    logic v;
    int hi, lo;
    if (n == 1) begin
      hi = 0;
      for (int i = 0; i < 32; i++) begin
        sampleBit(ch, v);
        if (v) hi++;
      end
      check(hi == 32, req, hi, 32);
    end else begin
      v = 1'b1;
      for (int i = 0; i < 64 && v; i++) sampleBit(ch, v);
      for (int i = 0; i < 64 && !v; i++) sampleBit(ch, v);
      hi = 0; lo = 0;
      for (int i = 0; i < 64 && v; i++) begin hi++; sampleBit(ch, v); end
      for (int i = 0; i < 64 && !v; i++) begin lo++; sampleBit(ch, v); end
      check(hi == n / 2, req, hi, n / 2);
      check(lo == n / 2, req, lo, n / 2);
    end
  endtask

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic v;
    int ones, lo1, hi2, lo2;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rdData == 8'h00, "R1 reset value", rdData, 0);
    check(chSleep == 2'b00, "R1 sleep flags", chSleep, 0);
    measure(0, 1, "R1 ch0 undivided");
    measure(1, 1, "R1 ch1 undivided");

    // R3: protection closed, then wrong address
    chResetMode = 2'b11; chSleepEnabled = 2'b11; protEn = 1'b0;
    doWrite(REG_ADDR, 8'h12);
    check(rdData == 8'h00, "R3 protect closed", rdData, 0);
    protEn = 1'b1;
    doWrite(REG_ADDR + 10'd1, 8'h12);
    check(rdData == 8'h00, "R3 wrong address", rdData, 0);

    // R8 and R2: every ratio on both channels
    for (int k = 0; k <= 4; k++) begin
      doWrite(REG_ADDR, {1'b0, 3'(4 - k), 1'b0, 3'(k)});
      check(rdData == model, "R2 readback", rdData, model);
      waitCycles(40);
      measure(0, 1 << k, "R8 ch0 ratio");
      measure(1, 1 << (4 - k), "R8 ch1 ratio");
    end

    // R5 / R7: reserved code on ch0, valid code on ch1
    doWrite(REG_ADDR, 8'h25);
    check(rdData[2:0] == 3'd4, "R5 reserved code kept", rdData[2:0], 4);
    check(rdData[6:4] == 3'd2, "R7 other field applied", rdData[6:4], 2);

    // R4: ch1 not in reset mode
    chResetMode = 2'b01;
    doWrite(REG_ADDR, 8'h31);
    check(rdData[2:0] == 3'd1, "R4 ch0 code applied", rdData[2:0], 1);
    check(rdData[6:4] == 3'd2, "R4 ch1 code locked", rdData[6:4], 2);

    // R6: sleep gated by sleep-enabled status
    chSleepEnabled = 2'b00;
    doWrite(REG_ADDR, 8'hA9);
    check(chSleep == 2'b00, "R6 sleep refused", chSleep, 0);
    chSleepEnabled = 2'b10;
    doWrite(REG_ADDR, 8'hA9);
    check(chSleep == 2'b10, "R6/R7 ch1 sleep only", chSleep, 2);
    check(rdData == model, "R7 mixed write", rdData, model);

    // R10: sleeping channel held low, other channel keeps running
    waitCycles(40);
    ones = 0;
    for (int i = 0; i < 24; i++) begin sampleBit(1, v); if (v) ones++; end
    check(ones == 0, "R10 sleeping output low", ones, 0);
    measure(0, 2, "R10 awake channel runs");
    chSleepEnabled = 2'b00;
    doWrite(REG_ADDR, 8'h21);
    check(chSleep == 2'b00, "R6 sleep cleared", chSleep, 0);
    waitCycles(40);
    measure(1, 4, "R10 wake resumes ratio");

    // R9: ratio change mid-period completes old period
    chResetMode = 2'b11;
    doWrite(REG_ADDR, 8'h24);
    waitCycles(40);
    v = 1'b1;
    for (int i = 0; i < 40 && v; i++) sampleBit(0, v);
    for (int i = 0; i < 40 && !v; i++) sampleBit(0, v);
    doWrite(REG_ADDR, 8'h21);
    v = 1'b1;
    for (int i = 0; i < 40 && v; i++) sampleBit(0, v);
    lo1 = 0; hi2 = 0; lo2 = 0;
    for (int i = 0; i < 40 && !v; i++) begin lo1++; sampleBit(0, v); end
    for (int i = 0; i < 40 && v; i++) begin hi2++; sampleBit(0, v); end
    for (int i = 0; i < 40 && !v; i++) begin lo2++; sampleBit(0, v); end
    check(lo1 == 8, "R9 old low phase complete", lo1, 8);
    check(hi2 == 1, "R9 new high phase", hi2, 1);
    check(lo2 == 1, "R9 new low phase", lo2, 1);

    // Random writes against the reference model (R3, R4, R5, R6, R7)
    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a;
      @(negedge clk);
      protEn = ($urandom % 4) != 0;
      chResetMode = 2'($urandom);
      chSleepEnabled = 2'($urandom);
      a = (($urandom % 4) != 0) ? REG_ADDR : ADDR_W'($urandom);
      doWrite(a, 8'($urandom));
      check(rdData == model, "R7 random write", rdData, model);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule